// File: doc/BRIEF.md
# NAND Flash Bus-Cycle Receiver

This block sits on the device side of an 8-bit asynchronous NAND flash bus. It samples the chip-select, latch-select, write-strobe, read-strobe and write-guard pins with a local clock. It finds the write-strobe rising edges and the read-strobe falling edges. Each write edge is classified from the latch levels as a command, address or data-in cycle. Each read edge inside a selected, latch-free window is a data-out cycle.

Commands go to a downstream core as one-cycle strobes. Address bytes are packed into a 12-bit column field and a 17-bit row field. A strobe marks the final address byte, after four or five byte cycles as set by a mode input. Program and erase commands are refused while the write guard is low. In that case a reject pulse is raised and no command is forwarded.

The guard is judged from its level at the moment of the command cycle. It is never held in a latch. While the chip is deselected, every strobe edge is ignored and the data output is switched off.

Top module: `nand_bus_frontend`

## Requirements
- R1: A write-strobe rising edge with sel_n low, cmd_lat high and addr_lat low produces a one-cycle cmd_valid, with cmd_code equal to the bus byte, two clock edges after the edge is sampled.
- R2: In four-byte mode (five_cyc low) the address bytes are packed as follows. Byte 1 gives col_addr[7:0]. Bits 3:0 of byte 2 give col_addr[11:8], and bits 7:4 of byte 2 are ignored. Byte 3 gives row_addr[7:0] and byte 4 gives row_addr[15:8]. row_addr[16] is 0. addr_valid pulses once, together with the fields, after the fourth byte only.
- R3: In five-byte mode (five_cyc high), bit 0 of byte 5 gives row_addr[16] and its other bits are ignored. addr_valid pulses after the fifth byte and not after the fourth.
- R4: Address bytes beyond the configured count raise no addr_valid and leave col_addr and row_addr unchanged.
- R5: A command cycle restarts address byte counting, so the next address byte is treated as byte 1.
- R6: A write edge with sel_n, addr_lat and cmd_lat all low produces a one-cycle din_valid, with din_data equal to the bus byte.
- R7: A read-strobe falling edge while the chip is selected, both latch pins are low and wr_n is high produces a one-cycle rd_take. In that same cycle io_oe is high and io_out equals the rd_data value presented at the edge. io_out stays driven while rd_n is low.
- R8: While sel_n is high, write edges produce no strobe of any kind, and io_oe is low.
- R9: The codes 0x80 and 0x10 (program) and 0x60 and 0xD0 (erase), received while wp_n is low, produce cmd_rejected instead of cmd_valid. Any other code is forwarded whatever the level of wp_n.
- R10: The guard is taken from the wp_n level sampled with the write edge itself. A low level earlier in the cycle does not block a command whose edge sees wp_n high, and a level that changes together with the edge is honoured.
- R11: A write edge with both addr_lat and cmd_lat high produces no strobe.
- R12: After reset all strobes and io_oe are low and both address fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| addr_lat | input | 1 | Address latch select |
| cmd_lat | input | 1 | Command latch select |
| wr_n | input | 1 | Write strobe, byte taken on rising edge |
| rd_n | input | 1 | Read strobe, byte driven after falling edge |
| wp_n | input | 1 | Write guard, low blocks program and erase |
| io_in | input | 8 | Bus byte from host |
| five_cyc | input | 1 | 1: five address bytes, 0: four |
| rd_data | input | 8 | Byte offered by the core for the next read |
| io_out | output | 8 | Bus byte to host |
| io_oe | output | 1 | Bus output enable |
| rd_take | output | 1 | Core byte consumed by a read cycle |
| cmd_valid | output | 1 | Accepted command strobe |
| cmd_code | output | 8 | Accepted command byte |
| cmd_rejected | output | 1 | Program or erase refused by the guard |
| addr_valid | output | 1 | Address complete strobe |
| col_addr | output | 12 | Column field |
| row_addr | output | 17 | Row field |
| din_valid | output | 1 | Data-in strobe |
| din_data | output | 8 | Data-in byte |

## Verification
Two functions can meet in one cycle: the guard decision and the command capture. A change on wp_n can land in the same sampling cycle as the write-strobe edge of a program or erase command. The bench provokes this by driving wp_n and wr_n at the same instant, in both directions. It expects a reject when the guard drops with the edge and a forwarded command when the guard rises with the edge. The bench also checks that a guard level held low earlier in the cycle has no lasting effect.

// File: rtl/nand_fe_pkg.sv
// Package: shared widths, pin bundle and write-cycle classes for the
// NAND bus receiver. Assumes an 8-bit bus.
package nand_fe_pkg;

    localparam int IO_W  = 8;
    localparam int COL_W = 12;
    localparam int ROW_W = 17;

    typedef enum logic [1:0] {
        WCYC_NONE = 2'd0,
        WCYC_CMD  = 2'd1,
        WCYC_ADDR = 2'd2,
        WCYC_DIN  = 2'd3
    } wcyc_t;

    typedef struct packed {
        logic            sel_n;
        logic            addr_lat;
        logic            cmd_lat;
        logic            wr_n;
        logic            rd_n;
        logic            wp_n;
        logic [IO_W-1:0] io;
    } pins_t;

    // Map latch levels to a write-cycle class; deselected or both latches high gives none.
    function automatic wcyc_t classify(input logic sel_n, input logic al, input logic cl);
        wcyc_t k;
        if (sel_n)           k = WCYC_NONE;
        else if (al && cl)   k = WCYC_NONE;
        else if (cl)         k = WCYC_CMD;
        else if (al)         k = WCYC_ADDR;
        else                 k = WCYC_DIN;
        return k;
    endfunction

endpackage

// File: rtl/nand_fe_sampler.sv
// Module: registers the asynchronous bus pins once in the local clock domain
// and flags write-strobe rises and read-strobe falls.
// Assumes strobe pulses last at least two clock periods (no metastability
// hardening; a synchroniser stage may be added in front by the integrator).
module nand_fe_sampler
    import nand_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins,
    output pins_t pin_q,
    output logic  wr_rise,
    output logic  rd_fall
);

    logic wr_prev;
    logic rd_prev;

    // Capture the pin bundle; reset to an idle, deselected bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q       <= '0;
            pin_q.sel_n <= 1'b1;
            pin_q.wr_n  <= 1'b1;
            pin_q.rd_n  <= 1'b1;
            wr_prev     <= 1'b1;
            rd_prev     <= 1'b1;
        end else begin
            pin_q   <= pins;
            wr_prev <= pin_q.wr_n;
            rd_prev <= pin_q.rd_n;
        end
    end

    // Edge flags from the current and previous sampled strobe levels.
    always_comb begin
        wr_rise = pin_q.wr_n & ~wr_prev;
        rd_fall = ~pin_q.rd_n & rd_prev;
    end

endmodule

// File: rtl/nand_fe_cmd_gate.sv
// Module: forwards command bytes, refusing program/erase codes while the
// write guard sampled with the edge is low. Assumes a cmd_hit qualifier
// already includes chip select and latch decoding.
module nand_fe_cmd_gate
    import nand_fe_pkg::*;
#(
    parameter int                    N_PROT     = 4,
    parameter logic [N_PROT*IO_W-1:0] PROT_CODES = {8'h80, 8'h10, 8'h60, 8'hD0}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_hit,
    input  logic            wp_n,
    input  logic [IO_W-1:0] code,
    output logic            cmd_valid,
    output logic [IO_W-1:0] cmd_code,
    output logic            cmd_rejected
);

    logic [N_PROT-1:0] match;
    logic              guarded;

    // One comparator per protected code.
    for (genvar g = 0; g < N_PROT; g++) begin : g_prot
        assign match[g] = (code == PROT_CODES[g*IO_W +: IO_W]);
    end

    // A code is refused only if protected and the guard is low now.
    assign guarded = (|match) & ~wp_n;

    // Issue either the forward strobe or the reject strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid    <= 1'b0;
            cmd_code     <= '0;
            cmd_rejected <= 1'b0;
        end else begin
            cmd_valid    <= cmd_hit & ~guarded;
            cmd_rejected <= cmd_hit & guarded;
            if (cmd_hit && !guarded) cmd_code <= code;
        end
    end

endmodule

// File: rtl/nand_fe_addr_pack.sv
// Module: packs four or five address bytes into column and row fields.
// Assumes addr_hit/restart are single-cycle and never both high.
module nand_fe_addr_pack
    import nand_fe_pkg::*;
#(
    parameter int MAX_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             addr_hit,
    input  logic             five_cyc,
    input  logic [IO_W-1:0]  byte_in,
    output logic             addr_valid,
    output logic [COL_W-1:0] col_addr,
    output logic [ROW_W-1:0] row_addr
);

    localparam int CNT_W = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] n_cyc;
    logic             take;
    logic             last;

    // Byte count for the selected mode; five only if the build allows it.
    if (MAX_CYC >= 5) begin : g_five
        assign n_cyc = five_cyc ? CNT_W'(5) : CNT_W'(4);
    end else begin : g_four
        logic unused_mode;
        assign unused_mode = five_cyc;
        assign n_cyc = CNT_W'(4);
    end

    assign take = addr_hit && (cnt < n_cyc);
    assign last = take && (cnt == n_cyc - CNT_W'(1));

    // Byte counter: cleared by a command, saturates at the configured count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (take)    cnt <= cnt + CNT_W'(1);
    end

    // Steer each accepted byte into its field slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_addr <= '0;
            row_addr <= '0;
        end else if (take) begin
            case (cnt)
                CNT_W'(0): begin
                    col_addr[7:0] <= byte_in;
                    row_addr[16]  <= 1'b0;
                end
                CNT_W'(1): col_addr[11:8]  <= byte_in[3:0];
                CNT_W'(2): row_addr[7:0]   <= byte_in;
                CNT_W'(3): row_addr[15:8]  <= byte_in;
                default:   row_addr[16]    <= byte_in[0];
            endcase
        end
    end

    // Completion strobe, aligned with the final field update.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_valid <= 1'b0;
        else        addr_valid <= last;
    end

endmodule

// File: rtl/nand_fe_rd_port.sv
// Module: read-side output stage. Latches the core byte on each read
// strobe fall and drives it while the read window stays open.
// Assumes rd_open is computed from the same sampled pins as rd_fall.
module nand_fe_rd_port
    import nand_fe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_fall,
    input  logic            rd_open,
    input  logic            sel_n,
    input  logic [IO_W-1:0] rd_data,
    output logic            rd_take,
    output logic [IO_W-1:0] io_out,
    output logic            io_oe
);

    logic            oe_q;
    logic [IO_W-1:0] data_q;

    // Capture the byte and pulse the take strobe on a qualified fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            rd_take <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            rd_take <= rd_fall & rd_open;
            oe_q    <= rd_open;
            if (rd_fall && rd_open) data_q <= rd_data;
        end
    end

    // Deselection cuts the driver at once, without waiting for a clock.
    always_comb begin
        io_oe  = oe_q & ~sel_n;
        io_out = io_oe ? data_q : '0;
    end

endmodule

// File: rtl/nand_bus_frontend.sv
// Module: top of the NAND bus receiver. Samples the pins, classifies write
// cycles, and fans out to the command gate, address packer, data-in path
// and read port. Assumes an 8-bit bus and a clock at least twice the
// strobe rate.
module nand_bus_frontend
    import nand_fe_pkg::*;
#(
    parameter int MAX_ADDR_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             addr_lat,
    input  logic             cmd_lat,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             wp_n,
    input  logic [7:0]       io_in,
    input  logic             five_cyc,
    input  logic [7:0]       rd_data,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             rd_take,
    output logic             cmd_valid,
    output logic [7:0]       cmd_code,
    output logic             cmd_rejected,
    output logic             addr_valid,
    output logic [11:0]      col_addr,
    output logic [16:0]      row_addr,
    output logic             din_valid,
    output logic [7:0]       din_data
);

    pins_t pins;
    pins_t pin_q;
    logic  wr_rise;
    logic  rd_fall;
    wcyc_t kind;
    logic  cmd_hit;
    logic  addr_hit;
    logic  din_hit;
    logic  rd_open;

    // Bundle the raw pins.
    always_comb begin
        pins.sel_n    = sel_n;
        pins.addr_lat = addr_lat;
        pins.cmd_lat  = cmd_lat;
        pins.wr_n     = wr_n;
        pins.rd_n     = rd_n;
        pins.wp_n     = wp_n;
        pins.io       = io_in;
    end

    nand_fe_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (pins),
        .pin_q   (pin_q),
        .wr_rise (wr_rise),
        .rd_fall (rd_fall)
    );

    // Decode the write-cycle class and the read window from sampled pins.
    always_comb begin
        kind     = classify(pin_q.sel_n, pin_q.addr_lat, pin_q.cmd_lat);
        cmd_hit  = wr_rise && (kind == WCYC_CMD);
        addr_hit = wr_rise && (kind == WCYC_ADDR);
        din_hit  = wr_rise && (kind == WCYC_DIN);
        rd_open  = ~pin_q.sel_n & ~pin_q.addr_lat & ~pin_q.cmd_lat
                 & pin_q.wr_n & ~pin_q.rd_n;
    end

    nand_fe_cmd_gate u_cmd_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_hit      (cmd_hit),
        .wp_n         (pin_q.wp_n),
        .code         (pin_q.io),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .cmd_rejected (cmd_rejected)
    );

    nand_fe_addr_pack #(.MAX_CYC(MAX_ADDR_CYC)) u_addr_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cmd_hit),
        .addr_hit   (addr_hit),
        .five_cyc   (five_cyc),
        .byte_in    (pin_q.io),
        .addr_valid (addr_valid),
        .col_addr   (col_addr),
        .row_addr   (row_addr)
    );

    // Data-in path: one strobe per write edge outside the latch phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_valid <= 1'b0;
            din_data  <= '0;
        end else begin
            din_valid <= din_hit;
            if (din_hit) din_data <= pin_q.io;
        end
    end

    nand_fe_rd_port u_rd_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fall (rd_fall),
        .rd_open (rd_open),
        .sel_n   (sel_n),
        .rd_data (rd_data),
        .rd_take (rd_take),
        .io_out  (io_out),
        .io_oe   (io_oe)
    );

endmodule

// File: rtl/nand_bus_frontend_chk.sv
// Checker: port-level temporal properties of the NAND bus receiver.
module nand_bus_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic addr_lat,
    input logic cmd_lat,
    input logic wr_n,
    input logic rd_n,
    input logic wp_n,
    input logic io_oe,
    input logic rd_take,
    input logic cmd_valid,
    input logic cmd_rejected,
    input logic addr_valid,
    input logic din_valid
);

    p_cmd_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(!sel_n && cmd_lat && !addr_lat));

    p_addr_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> $past(!sel_n && addr_lat && !cmd_lat));

    p_din_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid |-> $past(!sel_n && !addr_lat && !cmd_lat));

    p_read_needs_wr_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> $past(wr_n && !rd_n));

    p_no_strobe_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || cmd_rejected || addr_valid || din_valid) |-> !$past(sel_n));

    p_reject_needs_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rejected |-> $past(!wp_n));

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, cmd_rejected, addr_valid, din_valid}));

    p_oe_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> $past(!rd_n));

endmodule

bind nand_bus_frontend nand_bus_frontend_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .addr_lat     (addr_lat),
    .cmd_lat      (cmd_lat),
    .wr_n         (wr_n),
    .rd_n         (rd_n),
    .wp_n         (wp_n),
    .io_oe        (io_oe),
    .rd_take      (rd_take),
    .cmd_valid    (cmd_valid),
    .cmd_rejected (cmd_rejected),
    .addr_valid   (addr_valid),
    .din_valid    (din_valid)
);

// File: tb/test_nand_bus_frontend.sv
module test_nand_bus_frontend;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_n, addr_lat, cmd_lat, wr_n, rd_n, wp_n, five_cyc;
    logic [7:0]  io_in, rd_data;
    logic [7:0]  io_out, cmd_code, din_data;
    logic        io_oe, rd_take, cmd_valid, cmd_rejected, addr_valid, din_valid;
    logic [11:0] col_addr;
    logic [16:0] row_addr;

    int n_chk  = 0;
    int n_fail = 0;

    // Snapshots taken after each bus cycle.
    logic        s_cmd, s_rej, s_addr, s_din;
    logic [7:0]  s_code, s_dd;
    logic [11:0] s_col;
    logic [16:0] s_row;

    always #4ns clk = ~clk;

    nand_bus_frontend i_nand_bus_frontend (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr_lat(addr_lat),
        .cmd_lat(cmd_lat), .wr_n(wr_n), .rd_n(rd_n), .wp_n(wp_n),
        .io_in(io_in), .five_cyc(five_cyc), .rd_data(rd_data),
        .io_out(io_out), .io_oe(io_oe), .rd_take(rd_take),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_rejected(cmd_rejected),
        .addr_valid(addr_valid), .col_addr(col_addr), .row_addr(row_addr),
        .din_valid(din_valid), .din_data(din_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One write cycle; wp_at_edge sets the guard together with the rising edge.
    task automatic bus_wr(input logic ce, input logic a, input logic c,
                          input logic [7:0] b, input logic wp_at_edge);
        @(negedge clk);
        sel_n = ce; addr_lat = a; cmd_lat = c; io_in = b; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; wp_n = wp_at_edge;
        @(posedge clk); @(posedge clk); @(negedge clk);
        s_cmd = cmd_valid; s_code = cmd_code; s_rej = cmd_rejected;
        s_addr = addr_valid; s_col = col_addr; s_row = row_addr;
        s_din = din_valid; s_dd = din_data;
    endtask

    task automatic t_reset();
        chk("R12 strobes", {cmd_valid, cmd_rejected, addr_valid, din_valid, rd_take}, 0);
        chk("R12 io_oe", io_oe, 0);
        chk("R12 col", col_addr, 0);
        chk("R12 row", row_addr, 0);
    endtask

    task automatic t_command();
        bus_wr(0, 0, 1, 8'h00, 1);
        chk("R1 valid", s_cmd, 1); chk("R1 code", s_code, 8'h00);
        bus_wr(0, 0, 1, 8'hFF, 0);
        chk("R9 non-protected forwarded", s_cmd, 1); chk("R9 code", s_code, 8'hFF);
    endtask

    task automatic t_addr4();
        five_cyc = 0;
        bus_wr(0, 0, 1, 8'h00, 1);
        bus_wr(0, 1, 0, 8'h34, 1); chk("R2 no early valid 1", s_addr, 0);
        bus_wr(0, 1, 0, 8'hF5, 1); chk("R2 no early valid 2", s_addr, 0);
        bus_wr(0, 1, 0, 8'h78, 1); chk("R2 no early valid 3", s_addr, 0);
        bus_wr(0, 1, 0, 8'h9A, 1);
        chk("R2 valid", s_addr, 1); chk("R2 col", s_col, 12'h534); chk("R2 row", s_row, 17'h09A78);
        bus_wr(0, 1, 0, 8'hAA, 1);
        chk("R4 extra no valid", s_addr, 0); chk("R4 col kept", col_addr, 12'h534);
        chk("R4 row kept", row_addr, 17'h09A78);
    endtask

    task automatic t_addr5();
        five_cyc = 1;
        bus_wr(0, 0, 1, 8'h80, 1);
        bus_wr(0, 1, 0, 8'h11, 1);
        bus_wr(0, 1, 0, 8'h02, 1);
        bus_wr(0, 1, 0, 8'h33, 1);
        bus_wr(0, 1, 0, 8'h44, 1); chk("R3 no valid at 4", s_addr, 0);
        bus_wr(0, 1, 0, 8'hFF, 1);
        chk("R3 valid", s_addr, 1); chk("R3 col", s_col, 12'h211); chk("R3 row", s_row, 17'h14433);
        bus_wr(0, 1, 0, 8'h00, 1);
        chk("R4 sixth ignored", s_addr, 0); chk("R4 row kept 5", row_addr, 17'h14433);
    endtask

    task automatic t_restart();
        five_cyc = 0;
        bus_wr(0, 0, 1, 8'h00, 1);
        bus_wr(0, 1, 0, 8'h01, 1);
        bus_wr(0, 1, 0, 8'h02, 1);
        bus_wr(0, 0, 1, 8'h05, 1);
        bus_wr(0, 1, 0, 8'hC1, 1);
        bus_wr(0, 1, 0, 8'h0D, 1); chk("R5 no valid after 2", s_addr, 0);
        bus_wr(0, 1, 0, 8'h22, 1);
        bus_wr(0, 1, 0, 8'h33, 1);
        chk("R5 valid after restart", s_addr, 1); chk("R5 col", s_col, 12'hDC1);
        chk("R5 row", s_row, 17'h03322);
    endtask

    task automatic t_data_in();
        bus_wr(0, 0, 0, 8'h5A, 1);
        chk("R6 valid", s_din, 1); chk("R6 data", s_dd, 8'h5A);
        bus_wr(0, 0, 0, 8'hC3, 1);
        chk("R6 data 2", s_dd, 8'hC3);
    endtask

    task automatic t_read();
        @(negedge clk);
        sel_n = 0; addr_lat = 0; cmd_lat = 0; wr_n = 1; rd_data = 8'hA7; rd_n = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R7 take", rd_take, 1); chk("R7 oe", io_oe, 1); chk("R7 out", io_out, 8'hA7);
        rd_data = 8'h11;
        @(negedge clk);
        chk("R7 take one cycle", rd_take, 0); chk("R7 out held", io_out, 8'hA7);
        sel_n = 1;
        #1ns chk("R8 oe off on deselect", io_oe, 0);
        rd_n = 1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_standby();
        bus_wr(1, 0, 1, 8'h00, 1);
        chk("R8 no cmd deselected", {s_cmd, s_rej}, 0);
        bus_wr(1, 0, 0, 8'h44, 1);
        chk("R8 no din deselected", s_din, 0);
        @(negedge clk); rd_n = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R8 oe low deselected", {io_oe, rd_take}, 0);
        rd_n = 1;
    endtask

    task automatic t_both_latches();
        bus_wr(0, 1, 1, 8'h00, 1);
        chk("R11 no strobe", {s_cmd, s_rej, s_addr, s_din}, 0);
    endtask

    task automatic t_guard();
        bus_wr(0, 0, 1, 8'h60, 0);
        chk("R9 erase rejected", s_rej, 1); chk("R9 erase not forwarded", s_cmd, 0);
        bus_wr(0, 0, 1, 8'h10, 0);
        chk("R9 confirm rejected", s_rej, 1);
        // Guard low during setup, high exactly at the edge.
        @(negedge clk); wp_n = 0;
        bus_wr(0, 0, 1, 8'h80, 1);
        chk("R10 rise with edge forwards", s_cmd, 1); chk("R10 no reject", s_rej, 0);
        // Guard high during setup, dropped exactly at the edge.
        bus_wr(0, 0, 1, 8'hD0, 0);
        chk("R10 drop with edge rejects", s_rej, 1); chk("R10 not forwarded", s_cmd, 0);
        wp_n = 1;
    endtask

    initial begin
        #(8ns * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 0; sel_n = 1; addr_lat = 0; cmd_lat = 0; wr_n = 1; rd_n = 1;
        wp_n = 1; io_in = 0; five_cyc = 0; rd_data = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_command();
        t_addr4();
        t_addr5();
        t_restart();
        t_data_in();
        t_read();
        t_standby();
        t_both_latches();
        t_guard();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule